// File: doc/BRIEF.md
# Clock Divider Mode Controller

This block is a power-management clock controller with one control register. A 2-bit divide field in the register sets how many oscillator cycles make one machine cycle. The choices are 4, 64 or 1024. From each machine cycle the block derives a one-cycle machine-cycle enable, a timer tick enable and a serial mode-2 tick enable. Logic elsewhere uses these enables so that it can run from the oscillator clock at a lower rate.

The block protects the divide field. The two slow settings can only be reached from the fast setting, and the reserved code can never be written. When the switchback bit is set, an acknowledged external interrupt or a serial start-bit edge returns the block to the fast setting.

A crystal-disable bit can shut the crystal down, but only while the ring oscillator is the selected clock source. When this bit is cleared, a warm-up counter restarts. After a fixed number of oscillator cycles the block raises a crystal-ready flag.

Top module: `clkDivModeCtl`

## Requirements
- R1: After reset, `rdData` reads 8'h04. The divide field is at bits [3:2] and reads 01. The switchback enable at bit 0 and the crystal-disable bit at bit 1 read 0. Bits [7:4] always read 0.
- R2: Divide codes are 01 for 4 cycles, 10 for 64 cycles and 11 for 1024 cycles. A write to bits [3:2] is accepted in three cases: the current code is 01, the new code is 01, or the new code equals the current code. An accepted write takes effect at the clock edge that samples `wrEn`.
- R3: A write of 00, or a write that moves directly between 10 and 11, leaves the divide field unchanged. The other bits of the same write still take effect.
- R4: `mcTick` is high for one cycle in every 4, 64 or 1024 cycles, matching the divide code.
- R5: `timerTick` pulses on every third `mcTick` when `timerMode` is 0, giving 12, 192 or 3072 cycles. It pulses on every `mcTick` when `timerMode` is 1. It is high only together with `mcTick`.
- R6: `serTick` pulses on every 16th `mcTick` when `serDouble` is 0, giving 64, 1024 or 16384 cycles. It pulses on every 8th `mcTick` when `serDouble` is 1. It is high only together with `mcTick`.
- R7: Each change of the divide field restarts all tick counters. The first `mcTick` in the new mode comes a full period after the change.
- R8: If switchback is enabled and `intAck` is high, the divide field is 01 after the next edge. This takes priority over a register write in the same cycle. With switchback disabled, `intAck` has no effect.
- R9: If switchback is enabled and `rxStartFall` is high, a pending switch is armed. The divide field becomes 01 at the edge that ends the next cycle in which `mcTick` is high. With switchback disabled, `rxStartFall` is ignored.
- R10: A write of 1 to bit 1 sets `xtalOff` only while `ringSel` is 1. Otherwise that write leaves the bit unchanged. A write of 0 to bit 1 always clears it.
- R11: While the crystal is disabled, `xtalReady` is 0. It rises WARM_CYCLES cycles after reset or after the crystal is enabled again, and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| ringSel | input | 1 | 1 while the ring oscillator is the clock source |
| timerMode | input | 1 | Timer tick at machine-cycle rate when 1 |
| serDouble | input | 1 | Doubled serial mode-2 rate when 1 |
| intAck | input | 1 | External interrupt acknowledged, vector jump starting |
| rxStartFall | input | 1 | Falling edge of a serial start bit detected |
| mcTick | output | 1 | Machine-cycle enable |
| timerTick | output | 1 | Timer clock enable |
| serTick | output | 1 | Serial mode-2 clock enable |
| xtalOff | output | 1 | Crystal disabled |
| xtalReady | output | 1 | Crystal warm-up complete |

## Verification
The hardest situation to reach is the deferred switchback after a serial start edge. It needs the slowest mode, switchback enabled and a single edge pulse. The divide field must then stay unchanged for up to a full 1024-cycle period until the next machine-cycle tick. The bench reaches this state by a legal route through the fast code. It then waits on the machine-cycle boundary while the reference model checks every cycle that the field has not changed early.

A further test issues a switchback and a conflicting divide write in the same cycle. A serial tick at the slowest rate is only seen after a run of 16384 cycles in that mode.

// File: rtl/clkDivPkg.sv
package clkDivPkg;
  typedef enum logic [1:0] {
    DIV_RSVD = 2'b00,
    DIV_FAST = 2'b01,
    DIV_MID  = 2'b10,
    DIV_SLOW = 2'b11
  } divMode_e;

  localparam int SW_BIT   = 0;
  localparam int XOFF_BIT = 1;
  localparam int DIV_LSB  = 2;

  typedef struct packed {
    divMode_e div;
    logic     restart;
    logic     xtalOn;
  } ctlStrobe_t;
endpackage

// File: rtl/clkDivCtl.sv
module clkDivCtl
  import clkDivPkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             ringSel,
  input  logic             intAck,
  input  logic             rxStartFall,
  input  logic             mcTick,
  output ctlStrobe_t       strobe,
  output logic [REG_W-1:0] rdData,
  output logic             xtalOff
);
  divMode_e divQ, divNext, wrDiv;
  logic swEnQ, swEnNext;
  logic xoffQ, xoffNext;
  logic pendQ, pendNext;
  logic legalWr, forceFast;

  always_comb begin
    wrDiv   = divMode_e'(wrData[DIV_LSB +: 2]);
    legalWr = wrEn && (wrDiv != DIV_RSVD) &&
              ((wrDiv == divQ) || (wrDiv == DIV_FAST) || (divQ == DIV_FAST));
    forceFast = (swEnQ && intAck) || (pendQ && mcTick);
    divNext = divQ;
    if (legalWr)   divNext = wrDiv;
    if (forceFast) divNext = DIV_FAST;
  end

  always_comb begin
    pendNext = pendQ;
    if (pendQ && mcTick)       pendNext = 1'b0;
    if (swEnQ && rxStartFall)  pendNext = 1'b1;
  end

  always_comb begin
    swEnNext = wrEn ? wrData[SW_BIT] : swEnQ;
    xoffNext = xoffQ;
    if (wrEn) begin
      if (!wrData[XOFF_BIT])  xoffNext = 1'b0;
      else if (ringSel)       xoffNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ  <= DIV_FAST;
      swEnQ <= 1'b0;
      xoffQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      divQ  <= divNext;
      swEnQ <= swEnNext;
      xoffQ <= xoffNext;
      pendQ <= pendNext;
    end
  end

  always_comb begin
    strobe.div     = divQ;
    strobe.restart = (divNext != divQ);
    strobe.xtalOn  = !xoffQ;
  end

  always_comb begin
    rdData                  = '0;
    rdData[DIV_LSB +: 2]    = divQ;
    rdData[SW_BIT]          = swEnQ;
    rdData[XOFF_BIT]        = xoffQ;
  end

  assign xtalOff = xoffQ;
endmodule

// File: rtl/clkDivPath.sv
module clkDivPath
  import clkDivPkg::*;
#(
  parameter int BASE_LOG2   = 2,
  parameter int STEP_LOG2   = 4,
  parameter int TMR_DIV     = 3,
  parameter int SER_SLOW    = 16,
  parameter int SER_FAST    = 8,
  parameter int WARM_CYCLES = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       timerMode,
  input  logic       serDouble,
  output logic       mcTick,
  output logic       timerTick,
  output logic       serTick,
  output logic       xtalReady
);
  localparam int MC_W   = BASE_LOG2 + 2 * STEP_LOG2;
  localparam int SUB_W  = $clog2(SER_SLOW + TMR_DIV + 1);
  localparam int WARM_W = $clog2(WARM_CYCLES);
  localparam int N_SUB  = 2;

  logic [MC_W-1:0] mcCnt, mcLast;

  always_comb begin
    case (strobe.div)
      DIV_MID:  mcLast = MC_W'((1 << (BASE_LOG2 + STEP_LOG2)) - 1);
      DIV_SLOW: mcLast = MC_W'((1 << (BASE_LOG2 + 2 * STEP_LOG2)) - 1);
      default:  mcLast = MC_W'((1 << BASE_LOG2) - 1);
    endcase
  end

  assign mcTick = (mcCnt == mcLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        mcCnt <= '0;
    else if (strobe.restart || mcTick) mcCnt <= '0;
    else                              mcCnt <= mcCnt + 1'b1;
  end

  logic [SUB_W-1:0] subLim [N_SUB];
  logic [N_SUB-1:0] subTick;

  assign subLim[0] = timerMode ? SUB_W'(1) : SUB_W'(TMR_DIV);
  assign subLim[1] = serDouble ? SUB_W'(SER_FAST) : SUB_W'(SER_SLOW);

  for (genvar g = 0; g < N_SUB; g++) begin : gSub
    logic [SUB_W-1:0] cnt;
    logic wrap;
    assign wrap = (cnt >= subLim[g] - 1'b1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cnt <= '0;
      else if (strobe.restart) cnt <= '0;
      else if (mcTick)         cnt <= wrap ? '0 : cnt + 1'b1;
    end
    assign subTick[g] = mcTick & wrap;
  end

  assign timerTick = subTick[0];
  assign serTick   = subTick[1];

  logic [WARM_W-1:0] warmCnt;
  logic readyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
      readyQ  <= 1'b0;
    end else if (!strobe.xtalOn) begin
      warmCnt <= '0;
      readyQ  <= 1'b0;
    end else if (!readyQ) begin
      if (warmCnt == WARM_W'(WARM_CYCLES - 1)) readyQ <= 1'b1;
      else                                     warmCnt <= warmCnt + 1'b1;
    end
  end

  assign xtalReady = readyQ;
endmodule

// File: rtl/clkDivModeCtl.sv
module clkDivModeCtl
  import clkDivPkg::*;
#(
  parameter int REG_W       = 8,
  parameter int BASE_LOG2   = 2,
  parameter int STEP_LOG2   = 4,
  parameter int TMR_DIV     = 3,
  parameter int SER_SLOW    = 16,
  parameter int SER_FAST    = 8,
  parameter int WARM_CYCLES = 65536
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             ringSel,
  input  logic             timerMode,
  input  logic             serDouble,
  input  logic             intAck,
  input  logic             rxStartFall,
  output logic             mcTick,
  output logic             timerTick,
  output logic             serTick,
  output logic             xtalOff,
  output logic             xtalReady
);
  ctlStrobe_t strobe;

  clkDivCtl #(.REG_W(REG_W)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ringSel(ringSel), .intAck(intAck), .rxStartFall(rxStartFall),
    .mcTick(mcTick), .strobe(strobe), .rdData(rdData), .xtalOff(xtalOff)
  );

  clkDivPath #(
    .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .TMR_DIV(TMR_DIV),
    .SER_SLOW(SER_SLOW), .SER_FAST(SER_FAST), .WARM_CYCLES(WARM_CYCLES)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .timerMode(timerMode), .serDouble(serDouble),
    .mcTick(mcTick), .timerTick(timerTick), .serTick(serTick),
    .xtalReady(xtalReady)
  );
endmodule

// File: rtl/clkDivModeChk.sv
module clkDivModeChk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] rdData,
  input logic             ringSel,
  input logic             intAck,
  input logic             mcTick,
  input logic             timerTick,
  input logic             serTick,
  input logic             xtalOff,
  input logic             xtalReady
);
  logic [1:0] modeF;
  assign modeF = rdData[3:2];

  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rstN)
    modeF != 2'b00);

  a_r3_no_mid_to_slow: assert property (@(posedge clk) disable iff (!rstN)
    (modeF == 2'b10) |=> (modeF != 2'b11));

  a_r3_no_slow_to_mid: assert property (@(posedge clk) disable iff (!rstN)
    (modeF == 2'b11) |=> (modeF != 2'b10));

  a_r5_timer_on_mc: assert property (@(posedge clk) disable iff (!rstN)
    timerTick |-> mcTick);

  a_r6_serial_on_mc: assert property (@(posedge clk) disable iff (!rstN)
    serTick |-> mcTick);

  a_r8_switchback: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && intAck) |=> (modeF == 2'b01));

  a_r10_xtal_guard: assert property (@(posedge clk) disable iff (!rstN)
    (!xtalOff && !ringSel) |=> !xtalOff);

  a_r11_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    xtalOff |=> !xtalReady);
endmodule

bind clkDivModeCtl clkDivModeChk #(.REG_W(REG_W)) uChk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .ringSel(ringSel),
  .intAck(intAck), .mcTick(mcTick), .timerTick(timerTick),
  .serTick(serTick), .xtalOff(xtalOff), .xtalReady(xtalReady)
);

// File: tb/sim_clkDivModeCtl.sv
`timescale 1ns/1ps
module sim_clkDivModeCtl;
  localparam int WARM = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic ringSel = 1'b0, timerMode = 1'b0, serDouble = 1'b0;
  logic intAck = 1'b0, rxStartFall = 1'b0;
  logic [7:0] rdData;
  logic mcTick, timerTick, serTick, xtalOff, xtalReady;

  always #2 clk = ~clk;

  clkDivModeCtl #(.WARM_CYCLES(WARM)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ringSel(ringSel), .timerMode(timerMode), .serDouble(serDouble),
    .intAck(intAck), .rxStartFall(rxStartFall), .mcTick(mcTick),
    .timerTick(timerTick), .serTick(serTick), .xtalOff(xtalOff),
    .xtalReady(xtalReady)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // behavioural reference state
  int mDiv = 1, mSw = 0, mXoff = 0, mPend = 0;
  int mMc = 0, mTs = 0, mSs = 0, mWarm = 0, mRdy = 0;

  function automatic int periodOf(int d);
    return (d == 3) ? 1024 : (d == 2) ? 64 : 4;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 1; mSw = 0; mXoff = 0; mPend = 0;
      mMc = 0; mTs = 0; mSs = 0; mWarm = 0; mRdy = 0;
    end else begin
      int per, tl, sl, nd, w, np;
      bit mcT;
      per = periodOf(mDiv);
      tl  = timerMode ? 1 : 3;
      sl  = serDouble ? 8 : 16;
      mcT = (mMc == per - 1);
      nd  = mDiv;
      if (wrEn) begin
        w = int'(wrData[3:2]);
        if (w != 0 && (w == mDiv || w == 1 || mDiv == 1)) nd = w;
      end
      if ((mSw == 1 && intAck) || (mPend == 1 && mcT)) nd = 1;
      np = mPend;
      if (mPend == 1 && mcT) np = 0;
      if (mSw == 1 && rxStartFall) np = 1;
      if (nd != mDiv) begin
        mMc = 0; mTs = 0; mSs = 0;
      end else begin
        mMc = mcT ? 0 : mMc + 1;
        if (mcT) begin
          mTs = (mTs >= tl - 1) ? 0 : mTs + 1;
          mSs = (mSs >= sl - 1) ? 0 : mSs + 1;
        end
      end
      if (mXoff == 1) begin
        mWarm = 0; mRdy = 0;
      end else if (mRdy == 0) begin
        if (mWarm == WARM - 1) mRdy = 1; else mWarm++;
      end
      if (wrEn) begin
        mSw = int'(wrData[0]);
        if (!wrData[1]) mXoff = 0;
        else if (ringSel) mXoff = 1;
      end
      mDiv = nd;
      mPend = np;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      int per, tl, sl;
      bit mcT;
      per = periodOf(mDiv);
      tl  = timerMode ? 1 : 3;
      sl  = serDouble ? 8 : 16;
      mcT = (mMc == per - 1);
      check("R1 R2 R3 R8 R9 R10 register", {24'd0, rdData},
            {24'd0, 4'd0, mDiv[1:0], mXoff[0], mSw[0]});
      check("R4 R7 mcTick", {31'd0, mcTick}, {31'd0, mcT});
      check("R5 timerTick", {31'd0, timerTick}, {31'd0, mcT && (mTs >= tl - 1)});
      check("R6 serTick", {31'd0, serTick}, {31'd0, mcT && (mSs >= sl - 1)});
      check("R11 xtalReady", {31'd0, xtalReady}, {31'd0, mRdy[0]});
    end
  end

  task automatic regWrite(logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset value", {24'd0, rdData}, 32'h04);

    // R4 R5 R6 fast mode, both rate options
    idle(200);
    timerMode = 1'b1; serDouble = 1'b1;
    idle(200);
    timerMode = 1'b0; serDouble = 1'b0;

    // R2 move to 64, R3 illegal jumps
    regWrite(8'h08);
    check("R2 fast to mid", {30'd0, rdData[3:2]}, 32'd2);
    idle(2000);
    regWrite(8'h0D);
    check("R3 mid to slow ignored", {30'd0, rdData[3:2]}, 32'd2);
    check("R3 other bits applied", {31'd0, rdData[0]}, 32'd1);
    regWrite(8'h00);
    check("R3 reserved code ignored", {30'd0, rdData[3:2]}, 32'd2);

    // R2 route to slow via fast, R6 slow serial tick
    regWrite(8'h04);
    regWrite(8'h0C);
    check("R2 fast to slow", {30'd0, rdData[3:2]}, 32'd3);
    idle(17000);
    regWrite(8'h08);
    check("R3 slow to mid ignored", {30'd0, rdData[3:2]}, 32'd3);

    // R8 switchback on interrupt acknowledge
    regWrite(8'h0D);
    idle(37);
    pulseAck();
    check("R8 switchback on ack", {30'd0, rdData[3:2]}, 32'd1);
    regWrite(8'h0C);
    pulseAck();
    check("R8 ack ignored without enable", {30'd0, rdData[3:2]}, 32'd3);

    // R8 priority over simultaneous write
    regWrite(8'h05);
    regWrite(8'h09);
    @(negedge clk); wrEn = 1'b1; wrData = 8'h0D; intAck = 1'b1;
    @(negedge clk); wrEn = 1'b0; intAck = 1'b0;
    check("R8 switchback beats write", {30'd0, rdData[3:2]}, 32'd1);

    // R9 deferred switchback on serial start edge
    regWrite(8'h0D);
    idle(100);
    @(negedge clk); rxStartFall = 1'b1;
    @(negedge clk); rxStartFall = 1'b0;
    check("R9 not yet switched", {30'd0, rdData[3:2]}, 32'd3);
    idle(2100);
    check("R9 switched at boundary", {30'd0, rdData[3:2]}, 32'd1);
    regWrite(8'h08);
    @(negedge clk); rxStartFall = 1'b1;
    @(negedge clk); rxStartFall = 1'b0;
    idle(200);
    check("R9 edge ignored without enable", {30'd0, rdData[3:2]}, 32'd2);

    // R10 crystal disable guard, R11 warm-up
    regWrite(8'h04);
    ringSel = 1'b0;
    regWrite(8'h06);
    check("R10 disable refused", {31'd0, xtalOff}, 32'd0);
    ringSel = 1'b1;
    regWrite(8'h06);
    check("R10 disable accepted", {31'd0, xtalOff}, 32'd1);
    idle(3);
    check("R11 ready cleared", {31'd0, xtalReady}, 32'd0);
    ringSel = 1'b0;
    regWrite(8'h04);
    check("R10 clear always allowed", {31'd0, xtalOff}, 32'd0);
    idle(WARM - 10);
    check("R11 still warming", {31'd0, xtalReady}, 32'd0);
    idle(20);
    check("R11 ready after warm-up", {31'd0, xtalReady}, 32'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule